// File: doc/BRIEF.md
# Dual-Port Shared Memory with Collision Arbitration and Mailbox Flags

This block is a 1024-word by 8-bit memory that two independent agents, called left and right, share through their own ports. Each port has a chip select, a write enable, an output enable, an address, write data and registered read data. Both ports run on one clock and may reach any word in the same cycle.

When both ports select the same word and at least one of them writes, an arbiter marks one port busy and drops that port's write, so the memory keeps the winner's data. A port that already held the word in the previous cycle keeps it. A fresh tie goes to the left port. Two reserved words at the top of the address space act as mailboxes. A write by one port to its partner's mailbox word raises the partner's interrupt flag. The partner clears the flag by reading that word.

A parameter selects the arbiter variant. A master builds the arbiter. A slave takes its busy flags as inputs, so that a master's busy outputs can drive several slaves placed side by side to build a wider word.

Top module: `dpram_mailbox`

## Requirements
- R1: A write on either port stores `wdata` at `addr`. A read presents the stored word on that port's `rdata` one clock after the address, and every one of the 1024 words can be written and read back.
- R2: While a port's `cs` is low, that port neither writes nor reads. A write attempted with `cs` low leaves the memory unchanged.
- R3: A port's `rdata` is zero in the cycle after one in which its `cs` or `oe` was low.
- R4: Both ports may read the same word in the same cycle. Neither busy flag is raised, and both ports return the word.
- R5: In master mode a busy flag is raised only when both `cs` are high, the addresses are equal and at least one port writes. In that case exactly one busy flag is high, in the same cycle as the request.
- R6: When neither port held the word in the previous cycle, the left port wins and `r_busy_o` is raised.
- R7: A port that, in the previous cycle, had `cs` high at that same address without being busy keeps priority over a port arriving there now. If both or neither held it, the left port wins.
- R8: A write from a port whose busy flag is high is dropped, and the word keeps the winner's data.
- R9: `l_irq` is set one clock after a non-busy right-port write to address 0x3FF. It is cleared one clock after a non-busy left-port read (`cs`=1, `we`=0) of 0x3FF. Otherwise it holds its value.
- R10: `r_irq` is set one clock after a non-busy left-port write to address 0x3FE, and is cleared one clock after a non-busy right-port read of 0x3FE.
- R11: In slave mode (`IS_MASTER`=0) each `busy_o` follows that port's `busy_i` in the same cycle, and a high `busy_i` blocks that port's write.
- R12: During and after synchronous reset both `rdata` outputs and both interrupt flags are zero, and with no access pending neither busy flag is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| l_cs | input | 1 | Left chip select |
| l_we | input | 1 | Left write enable (1 = write, 0 = read) |
| l_oe | input | 1 | Left output enable |
| l_addr | input | ADDR_W | Left word address |
| l_wdata | input | DATA_W | Left write data |
| l_rdata | output | DATA_W | Left registered read data |
| l_busy_i | input | 1 | Left busy input, used in slave mode only |
| l_busy_o | output | 1 | Left busy flag |
| l_irq | output | 1 | Left mailbox interrupt flag |
| r_cs | input | 1 | Right chip select |
| r_we | input | 1 | Right write enable (1 = write, 0 = read) |
| r_oe | input | 1 | Right output enable |
| r_addr | input | ADDR_W | Right word address |
| r_wdata | input | DATA_W | Right write data |
| r_rdata | output | DATA_W | Right registered read data |
| r_busy_i | input | 1 | Right busy input, used in slave mode only |
| r_busy_o | output | 1 | Right busy flag |
| r_irq | output | 1 | Right mailbox interrupt flag |

## Verification
Busy flags are combinational on the current request, so the bench drives each request on the falling edge and checks busy one nanosecond later, before the rising edge that would commit the write. Read data and interrupt flags are registered one stage, so they are checked on the falling edge after the rising edge that took the request. A dropped write is shown by a later read of the same word, one cycle after that read's address. The sweeps write a computed pattern into all 1024 words and read every word back through both ports at once, so the reserved mailbox words and the shared-read rule are covered as the sweep passes them.

// File: rtl/dpm_pkg.sv
package dpm_pkg;

  typedef struct packed {
    logic cs;
    logic we;
    logic oe;
  } port_ctl_t;

  typedef enum logic {
    SIDE_L = 1'b0,
    SIDE_R = 1'b1
  } side_t;

  // Mailbox word owned by a side: left owns the top word, right the one below.
  function automatic logic [31:0] mbx_word(input side_t s, input int unsigned aw);
    logic [31:0] top;
    top = (32'd1 << aw) - 32'd1;
    return (s == SIDE_L) ? top : top - 32'd1;
  endfunction

endpackage

// File: rtl/dpm_arbiter.sv
module dpm_arbiter
  import dpm_pkg::*;
#(
  parameter int ADDR_W = 10
) (
  input  logic              clk,
  input  logic              rst,
  input  port_ctl_t         l_ctl,
  input  logic [ADDR_W-1:0] l_addr,
  input  port_ctl_t         r_ctl,
  input  logic [ADDR_W-1:0] r_addr,
  output logic              l_busy,
  output logic              r_busy
);

  logic              l_prev_v, r_prev_v;
  logic [ADDR_W-1:0] l_prev_a, r_prev_a;
  logic              clash, l_held, r_held, right_wins;

  always_comb begin
    clash      = l_ctl.cs && r_ctl.cs && (l_addr == r_addr) && (l_ctl.we || r_ctl.we);
    l_held     = l_prev_v && (l_prev_a == l_addr);
    r_held     = r_prev_v && (r_prev_a == r_addr);
    right_wins = r_held && !l_held;
    l_busy     = clash && right_wins;
    r_busy     = clash && !right_wins;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      l_prev_v <= 1'b0;
      r_prev_v <= 1'b0;
      l_prev_a <= '0;
      r_prev_a <= '0;
    end else begin
      l_prev_v <= l_ctl.cs && !l_busy;
      r_prev_v <= r_ctl.cs && !r_busy;
      l_prev_a <= l_addr;
      r_prev_a <= r_addr;
    end
  end

endmodule

// File: rtl/dpm_mailbox.sv
module dpm_mailbox
  import dpm_pkg::*;
#(
  parameter int ADDR_W = 10
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              l_wr,
  input  logic              l_rd,
  input  logic [ADDR_W-1:0] l_addr,
  input  logic              r_wr,
  input  logic              r_rd,
  input  logic [ADDR_W-1:0] r_addr,
  output logic              l_irq,
  output logic              r_irq
);

  localparam logic [31:0] L_WORD = mbx_word(SIDE_L, ADDR_W);
  localparam logic [31:0] R_WORD = mbx_word(SIDE_R, ADDR_W);

  logic [1:0]              wr_v, rd_v, flag;
  logic [1:0][ADDR_W-1:0]  wr_a, rd_a;
  logic [1:0][ADDR_W-1:0]  own_a;

  // Index 0 is the left flag, index 1 the right flag. A flag is set by the
  // partner's write and cleared by its owner's read of the owned word.
  always_comb begin
    own_a[0] = L_WORD[ADDR_W-1:0];
    own_a[1] = R_WORD[ADDR_W-1:0];
    wr_v[0]  = r_wr;  wr_a[0] = r_addr;
    wr_v[1]  = l_wr;  wr_a[1] = l_addr;
    rd_v[0]  = l_rd;  rd_a[0] = l_addr;
    rd_v[1]  = r_rd;  rd_a[1] = r_addr;
  end

  for (genvar s = 0; s < 2; s++) begin : g_flag
    always_ff @(posedge clk) begin
      if (rst) begin
        flag[s] <= 1'b0;
      end else if (wr_v[s] && (wr_a[s] == own_a[s])) begin
        flag[s] <= 1'b1;
      end else if (rd_v[s] && (rd_a[s] == own_a[s])) begin
        flag[s] <= 1'b0;
      end
    end
  end

  assign l_irq = flag[0];
  assign r_irq = flag[1];

endmodule

// File: rtl/dpm_array.sv
module dpm_array #(
  parameter int ADDR_W = 10,
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              l_wr,
  input  logic              l_rd,
  input  logic [ADDR_W-1:0] l_addr,
  input  logic [DATA_W-1:0] l_wdata,
  output logic [DATA_W-1:0] l_q,
  input  logic              r_wr,
  input  logic              r_rd,
  input  logic [ADDR_W-1:0] r_addr,
  input  logic [DATA_W-1:0] r_wdata,
  output logic [DATA_W-1:0] r_q
);

  localparam int DEPTH = 1 << ADDR_W;

  logic [DATA_W-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (l_wr) mem[l_addr] <= l_wdata;
    if (r_wr) mem[r_addr] <= r_wdata;
  end

  // Read-first output registers, cleared when the port is not driving.
  always_ff @(posedge clk) begin
    if (rst) begin
      l_q <= '0;
      r_q <= '0;
    end else begin
      l_q <= l_rd ? mem[l_addr] : '0;
      r_q <= r_rd ? mem[r_addr] : '0;
    end
  end

endmodule

// File: rtl/dpram_mailbox.sv
module dpram_mailbox
  import dpm_pkg::*;
#(
  parameter int ADDR_W    = 10,
  parameter int DATA_W    = 8,
  parameter bit IS_MASTER = 1'b1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              l_cs,
  input  logic              l_we,
  input  logic              l_oe,
  input  logic [ADDR_W-1:0] l_addr,
  input  logic [DATA_W-1:0] l_wdata,
  output logic [DATA_W-1:0] l_rdata,
  input  logic              l_busy_i,
  output logic              l_busy_o,
  output logic              l_irq,
  input  logic              r_cs,
  input  logic              r_we,
  input  logic              r_oe,
  input  logic [ADDR_W-1:0] r_addr,
  input  logic [DATA_W-1:0] r_wdata,
  output logic [DATA_W-1:0] r_rdata,
  input  logic              r_busy_i,
  output logic              r_busy_o,
  output logic              r_irq
);

  port_ctl_t l_ctl, r_ctl;
  logic      l_busy, r_busy;
  logic      l_wr, r_wr, l_rdclr, r_rdclr, l_out, r_out;

  assign l_ctl = '{cs: l_cs, we: l_we, oe: l_oe};
  assign r_ctl = '{cs: r_cs, we: r_we, oe: r_oe};

  if (IS_MASTER) begin : g_master
    logic unused_busy_in;
    assign unused_busy_in = l_busy_i ^ r_busy_i;
    dpm_arbiter #(.ADDR_W(ADDR_W)) u_arb (
      .clk    (clk),
      .rst    (rst),
      .l_ctl  (l_ctl),
      .l_addr (l_addr),
      .r_ctl  (r_ctl),
      .r_addr (r_addr),
      .l_busy (l_busy),
      .r_busy (r_busy)
    );
  end else begin : g_slave
    assign l_busy = l_busy_i;
    assign r_busy = r_busy_i;
  end

  always_comb begin
    l_wr    = l_ctl.cs && l_ctl.we && !l_busy;
    r_wr    = r_ctl.cs && r_ctl.we && !r_busy;
    l_rdclr = l_ctl.cs && !l_ctl.we && !l_busy;
    r_rdclr = r_ctl.cs && !r_ctl.we && !r_busy;
    l_out   = l_ctl.cs && l_ctl.oe;
    r_out   = r_ctl.cs && r_ctl.oe;
  end

  dpm_array #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_array (
    .clk     (clk),
    .rst     (rst),
    .l_wr    (l_wr),
    .l_rd    (l_out),
    .l_addr  (l_addr),
    .l_wdata (l_wdata),
    .l_q     (l_rdata),
    .r_wr    (r_wr),
    .r_rd    (r_out),
    .r_addr  (r_addr),
    .r_wdata (r_wdata),
    .r_q     (r_rdata)
  );

  dpm_mailbox #(.ADDR_W(ADDR_W)) u_mbx (
    .clk    (clk),
    .rst    (rst),
    .l_wr   (l_wr),
    .l_rd   (l_rdclr),
    .l_addr (l_addr),
    .r_wr   (r_wr),
    .r_rd   (r_rdclr),
    .r_addr (r_addr),
    .l_irq  (l_irq),
    .r_irq  (r_irq)
  );

  assign l_busy_o = l_busy;
  assign r_busy_o = r_busy;

endmodule

// File: rtl/dpm_checker.sv
module dpm_checker #(
  parameter int ADDR_W    = 10,
  parameter int DATA_W    = 8,
  parameter bit IS_MASTER = 1'b1
) (
  input logic              clk,
  input logic              rst,
  input logic              l_cs,
  input logic              l_we,
  input logic              l_oe,
  input logic [ADDR_W-1:0] l_addr,
  input logic [DATA_W-1:0] l_rdata,
  input logic              l_busy_i,
  input logic              l_busy_o,
  input logic              l_irq,
  input logic              r_cs,
  input logic              r_we,
  input logic              r_oe,
  input logic [ADDR_W-1:0] r_addr,
  input logic [DATA_W-1:0] r_rdata,
  input logic              r_busy_i,
  input logic              r_busy_o,
  input logic              r_irq
);

  localparam logic [ADDR_W-1:0] TOP_A  = '1;
  localparam logic [ADDR_W-1:0] NEXT_A = TOP_A - 1'b1;

  logic same_word, any_wr, clash;
  assign same_word = l_cs && r_cs && (l_addr == r_addr);
  assign any_wr    = l_we || r_we;
  assign clash     = same_word && any_wr;

  p_dout_idle_l_r3: assert property (@(posedge clk) disable iff (rst)
    !(l_cs && l_oe) |=> (l_rdata == '0));
  p_dout_idle_r_r3: assert property (@(posedge clk) disable iff (rst)
    !(r_cs && r_oe) |=> (r_rdata == '0));

  p_irq_set_r9: assert property (@(posedge clk) disable iff (rst)
    (r_cs && r_we && !r_busy_o && r_addr == TOP_A) |=> l_irq);
  p_irq_clr_r9: assert property (@(posedge clk) disable iff (rst)
    (l_cs && !l_we && !l_busy_o && l_addr == TOP_A) |=> !l_irq);
  p_irq_set_r10: assert property (@(posedge clk) disable iff (rst)
    (l_cs && l_we && !l_busy_o && l_addr == NEXT_A) |=> r_irq);
  p_irq_clr_r10: assert property (@(posedge clk) disable iff (rst)
    (r_cs && !r_we && !r_busy_o && r_addr == NEXT_A) |=> !r_irq);

  if (IS_MASTER) begin : g_master_chk
    p_busy_cause_r5: assert property (@(posedge clk) disable iff (rst)
      (l_busy_o || r_busy_o) |-> clash);
    p_one_winner_r5: assert property (@(posedge clk) disable iff (rst)
      clash |-> ($countones({l_busy_o, r_busy_o}) == 1));
    p_shared_read_r4: assert property (@(posedge clk) disable iff (rst)
      (same_word && !any_wr) |-> (!l_busy_o && !r_busy_o));
  end else begin : g_slave_chk
    p_busy_follow_r11: assert property (@(posedge clk) disable iff (rst)
      (l_busy_o == l_busy_i) && (r_busy_o == r_busy_i));
  end

endmodule

bind dpram_mailbox dpm_checker #(
  .ADDR_W    (ADDR_W),
  .DATA_W    (DATA_W),
  .IS_MASTER (IS_MASTER)
) u_chk (
  .clk      (clk),
  .rst      (rst),
  .l_cs     (l_cs),
  .l_we     (l_we),
  .l_oe     (l_oe),
  .l_addr   (l_addr),
  .l_rdata  (l_rdata),
  .l_busy_i (l_busy_i),
  .l_busy_o (l_busy_o),
  .l_irq    (l_irq),
  .r_cs     (r_cs),
  .r_we     (r_we),
  .r_oe     (r_oe),
  .r_addr   (r_addr),
  .r_rdata  (r_rdata),
  .r_busy_i (r_busy_i),
  .r_busy_o (r_busy_o),
  .r_irq    (r_irq)
);

// File: tb/tb_dpram_mailbox.sv
module tb_dpram_mailbox;

  localparam int AW    = 10;
  localparam int DW    = 8;
  localparam int DEPTH = 1 << AW;
  localparam logic [AW-1:0] TOP_A  = 10'h3FF;
  localparam logic [AW-1:0] NEXT_A = 10'h3FE;

  logic clk = 1'b0;
  logic rst = 1'b1;
  always #5 clk = ~clk;

  logic          l_cs = 0, l_we = 0, l_oe = 0, r_cs = 0, r_we = 0, r_oe = 0;
  logic [AW-1:0] l_addr = '0, r_addr = '0;
  logic [DW-1:0] l_wdata = '0, r_wdata = '0;
  logic [DW-1:0] l_rdata, r_rdata;
  logic          l_busy_o, r_busy_o, l_irq, r_irq;

  logic          s_cs = 0, s_we = 0, s_oe = 0, s_busy_i = 0;
  logic [AW-1:0] s_addr = '0;
  logic [DW-1:0] s_wdata = '0;
  logic [DW-1:0] s_l_rdata, s_r_rdata;
  logic          s_l_busy_o, s_r_busy_o, s_l_irq, s_r_irq;

  dpram_mailbox #(.ADDR_W(AW), .DATA_W(DW), .IS_MASTER(1'b1)) dut (
    .clk(clk), .rst(rst),
    .l_cs(l_cs), .l_we(l_we), .l_oe(l_oe), .l_addr(l_addr), .l_wdata(l_wdata),
    .l_rdata(l_rdata), .l_busy_i(1'b0), .l_busy_o(l_busy_o), .l_irq(l_irq),
    .r_cs(r_cs), .r_we(r_we), .r_oe(r_oe), .r_addr(r_addr), .r_wdata(r_wdata),
    .r_rdata(r_rdata), .r_busy_i(1'b0), .r_busy_o(r_busy_o), .r_irq(r_irq)
  );

  dpram_mailbox #(.ADDR_W(AW), .DATA_W(DW), .IS_MASTER(1'b0)) dut_slave (
    .clk(clk), .rst(rst),
    .l_cs(s_cs), .l_we(s_we), .l_oe(s_oe), .l_addr(s_addr), .l_wdata(s_wdata),
    .l_rdata(s_l_rdata), .l_busy_i(s_busy_i), .l_busy_o(s_l_busy_o), .l_irq(s_l_irq),
    .r_cs(1'b0), .r_we(1'b0), .r_oe(1'b0), .r_addr('0), .r_wdata('0),
    .r_rdata(s_r_rdata), .r_busy_i(1'b0), .r_busy_o(s_r_busy_o), .r_irq(s_r_irq)
  );

  int checks = 0;
  int errors = 0;
  logic [DW-1:0] model [DEPTH];

  function automatic logic [DW-1:0] pat(input int a);
    return DW'((a * 37 + 11) ^ (a >> 3));
  endfunction

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s act=%0h exp=%0h", req, act, exp);
    end
  endtask

  task automatic step();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic idle();
    l_cs = 0; l_we = 0; l_oe = 0;
    r_cs = 0; r_we = 0; r_oe = 0;
  endtask

  task automatic drv_l(input logic we, input logic [AW-1:0] a, input logic [DW-1:0] d);
    l_cs = 1; l_we = we; l_oe = !we; l_addr = a; l_wdata = d;
  endtask

  task automatic drv_r(input logic we, input logic [AW-1:0] a, input logic [DW-1:0] d);
    r_cs = 1; r_we = we; r_oe = !we; r_addr = a; r_wdata = d;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog act=running exp=done");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    // R12: reset state
    chk("R12 l_rdata", l_rdata, 0);
    chk("R12 r_rdata", r_rdata, 0);
    chk("R12 l_irq", l_irq, 0);
    chk("R12 r_irq", r_irq, 0);
    rst = 0;
    step();
    chk("R12 busy idle", {l_busy_o, r_busy_o}, 0);

    // R1: write every word through the left port
    for (int a = 0; a < DEPTH; a++) begin
      idle();
      drv_l(1, AW'(a), pat(a));
      #1 chk("R1 no busy on lone write", l_busy_o, 0);
      step();
      model[a] = pat(a);
    end
    idle();
    chk("R10 r_irq set by sweep write of 0x3FE", r_irq, 1);
    chk("R9 l_irq untouched by left writes", l_irq, 0);

    // R1/R4: both ports read each word together
    for (int a = 0; a < DEPTH; a++) begin
      drv_l(0, AW'(a), '0);
      drv_r(0, AW'(a), '0);
      #1 chk("R4 no busy on shared read", {l_busy_o, r_busy_o}, 0);
      step();
      chk("R1 right readback", r_rdata, model[a]);
      chk("R4 left readback", l_rdata, model[a]);
    end
    idle();
    chk("R10 r_irq cleared by right read of 0x3FE", r_irq, 0);

    // R3: output enable low zeroes the read data
    drv_l(0, 10'd5, '0); l_oe = 0;
    step();
    chk("R3 oe low gives zero", l_rdata, 0);
    // R2: chip select low blocks the write and the read
    idle(); l_we = 1; l_addr = 10'd5; l_wdata = 8'hAA; l_oe = 1;
    step();
    chk("R2 cs low gives zero", l_rdata, 0);
    idle(); drv_l(0, 10'd5, '0);
    step();
    chk("R2 write with cs low ignored", l_rdata, model[5]);

    // R5: different addresses, both write, no busy
    idle(); step();
    drv_l(1, 10'd100, 8'h3C); drv_r(1, 10'd101, 8'hC3);
    #1 chk("R5 no busy on distinct addresses", {l_busy_o, r_busy_o}, 0);
    step(); model[100] = 8'h3C; model[101] = 8'hC3;

    // R6: fresh same-word writes, left wins
    idle(); step();
    drv_l(1, 10'd10, 8'h11); drv_r(1, 10'd10, 8'h22);
    #1 chk("R6 left wins fresh tie", {l_busy_o, r_busy_o}, 2'b01);
    step(); model[10] = 8'h11;
    idle(); drv_l(0, 10'd10, '0);
    step();
    chk("R8 winner data kept", l_rdata, model[10]);

    // R7: right holds the word, left write arrives and is blocked
    idle(); step();
    drv_r(0, 10'd20, '0);
    step();
    drv_l(1, 10'd20, 8'h55);
    #1 chk("R7 holder keeps priority", {l_busy_o, r_busy_o}, 2'b10);
    chk("R5 read vs write busy", l_busy_o | r_busy_o, 1);
    step();
    idle(); drv_l(0, 10'd20, '0);
    step();
    chk("R8 busy write dropped", l_rdata, model[20]);
    chk("R1 distinct reads", l_rdata, model[20]);

    // R9: right writes 0x3FF, left reads it back
    idle(); drv_r(1, TOP_A, 8'h77);
    step(); model[TOP_A] = 8'h77;
    chk("R9 l_irq set", l_irq, 1);
    chk("R10 r_irq not set by 0x3FF", r_irq, 0);
    idle(); drv_l(0, TOP_A, '0);
    step();
    chk("R9 mailbox data", l_rdata, 8'h77);
    chk("R9 l_irq cleared", l_irq, 0);

    // R10: left writes 0x3FE, right reads it back
    idle(); drv_l(1, NEXT_A, 8'h66);
    step(); model[NEXT_A] = 8'h66;
    chk("R10 r_irq set", r_irq, 1);
    idle(); drv_r(0, NEXT_A, '0);
    step();
    chk("R10 mailbox data", r_rdata, 8'h66);
    chk("R10 r_irq cleared", r_irq, 0);

    // R9/R8: blocked right write to 0x3FF does not raise l_irq
    idle(); step();
    drv_l(1, TOP_A, 8'h01); drv_r(1, TOP_A, 8'h02);
    #1 chk("R6 left wins at mailbox", {l_busy_o, r_busy_o}, 2'b01);
    step(); model[TOP_A] = 8'h01;
    chk("R9 blocked write leaves l_irq low", l_irq, 0);
    idle(); drv_r(0, TOP_A, '0);
    step();
    chk("R8 mailbox holds winner data", r_rdata, 8'h01);
    idle(); step();

    // R11: slave mode
    s_cs = 1; s_we = 1; s_oe = 0; s_addr = 10'd30; s_wdata = 8'h12; s_busy_i = 0;
    #1 chk("R11 busy_o low follows busy_i", s_l_busy_o, 0);
    step();
    s_wdata = 8'h99; s_busy_i = 1;
    #1 chk("R11 busy_o high follows busy_i", s_l_busy_o, 1);
    step();
    s_busy_i = 0; s_we = 0; s_oe = 1;
    step();
    chk("R11 busy_i blocks write", s_l_rdata, 8'h12);
    s_cs = 0;
    step();

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule